// File: doc/BRIEF.md
# Sample Offset and Output Formatter

This block sits between a converter's sample path and its output port. Each raw unsigned sample arrives with a valid flag. The block adds a signed correction of a few LSBs to the sample and clamps the sum to the legal code range. It then recodes the result as offset binary, two's complement or Gray code.

An optional bitwise inversion follows the coding step. A disable control parks the port at all zeros with the valid flag low. The path has a fixed latency of two clock cycles. The first register stage holds the corrected sample and the second holds the formatted word.

The offset is applied with the configuration present in the cycle the sample enters. Coding, inversion and disable act on the configuration present one cycle later, when the corrected sample moves to the output stage.

Top module: `sample_fmt`

## Requirements
- R1: After reset `out_valid` is 0 and `out_data` is 0.
- R2: A sample presented with `in_valid` high appears at the output two rising edges later, with `out_valid` high, provided the port is enabled.
- R3: `cfg_offset` is an 8-bit two's complement value in the range −128 to +127. It is added to the 14-bit unsigned sample.
- R4: A sum above 0x3FFF is clamped to 0x3FFF.
- R5: A sum below 0 is clamped to 0.
- R6: `cfg_format` = 2'b00 selects offset binary: the corrected value is output unchanged.
- R7: `cfg_format` = 2'b01 selects two's complement: bit 13 of the corrected value is inverted.
- R8: `cfg_format` = 2'b10 selects Gray code: the value XOR the value shifted right by one.
- R9: `cfg_format` = 2'b11 behaves as offset binary.
- R10: With `cfg_invert` high, every bit of the coded word is complemented after coding.
- R11: When `cfg_disable` is high at a rising edge, that edge drives `out_data` to 0 and `out_valid` to 0.
- R12: When no valid sample reaches the output stage and the port is enabled, `out_data` keeps its last value and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw sample valid |
| in_sample | input | 14 | Raw unsigned sample |
| cfg_offset | input | 8 | Signed LSB correction |
| cfg_format | input | 2 | Output coding select |
| cfg_invert | input | 1 | Complement output word |
| cfg_disable | input | 1 | Park port at zero |
| out_valid | output | 1 | Formatted word valid |
| out_data | output | 14 | Formatted word |

## Verification
The bench builds the block with its default parameters: 14-bit data and an 8-bit offset. With these widths the clamping at both ends can be reached by driving samples within 128 codes of 0 or 0x3FFF. With the same widths the Gray and two's complement codings can be checked against easily computed integers. A behavioural reference model built from integers tracks the two-cycle delay. It is compared with both outputs on every clock while the coding, inversion, disable and valid gaps change mid-stream.

// File: rtl/sample_fmt.sv
module sample_fmt #(
  parameter int DW  = 14,
  parameter int OFW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_sample,
  input  logic [OFW-1:0] cfg_offset,
  input  logic [1:0]     cfg_format,
  input  logic           cfg_invert,
  input  logic           cfg_disable,
  output logic           out_valid,
  output logic [DW-1:0]  out_data
);
  localparam int SW = DW + 2;
  localparam logic [DW-1:0] MAXV = {DW{1'b1}};
  localparam logic [DW-1:0] MSB  = {1'b1, {(DW-1){1'b0}}};

  logic signed [SW-1:0] sum;
  logic [DW-1:0] clamped, s1_val, coded;
  logic s1_valid;

  assign sum = $signed({2'b00, in_sample}) + $signed({{(SW-OFW){cfg_offset[OFW-1]}}, cfg_offset});
  assign clamped = sum[SW-1] ? '0 : (sum[SW-2] ? MAXV : sum[DW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_val   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_val <= clamped;
    end
  end

  always_comb begin
    case (cfg_format)
      2'b01:   coded = s1_val ^ MSB;
      2'b10:   coded = s1_val ^ (s1_val >> 1);
      default: coded = s1_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid & ~cfg_disable;
      if (cfg_disable)   out_data <= '0;
      else if (s1_valid) out_data <= coded ^ {DW{cfg_invert}};
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_data == '0)); // R1
  AST_STAGE_ONE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> s1_valid); // R2
  AST_STAGE_TWO: assert property (@(posedge clk) disable iff (!rst_n) (s1_valid && !cfg_disable) |=> out_valid); // R2
  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sample == MAXV && !cfg_offset[OFW-1]) |=> s1_val == MAXV); // R4
  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sample == '0 && cfg_offset[OFW-1]) |=> s1_val == '0); // R5
  AST_DIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_disable |=> (!out_valid && out_data == '0)); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1_valid && !cfg_disable) |=> (!out_valid && $stable(out_data))); // R12
endmodule

// File: tb/sim_sample_fmt.sv
`timescale 1ns/1ps
module sim_sample_fmt;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [13:0] in_sample = 0;
  logic [7:0] cfg_offset = 0;
  logic [1:0] cfg_format = 0;
  logic cfg_invert = 0, cfg_disable = 0;
  logic out_valid;
  logic [13:0] out_data;
  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  sample_fmt u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_offset(cfg_offset), .cfg_format(cfg_format), .cfg_invert(cfg_invert),
    .cfg_disable(cfg_disable), .out_valid(out_valid), .out_data(out_data));

  int m1d = 0, m2d = 0;
  bit m1v = 0, m2v = 0;

  function automatic int clamp(int s, int off);
    int r = s + off;
    if (r < 0) r = 0;
    if (r > 16383) r = 16383;
    return r;
  endfunction

  function automatic int code(int v, int f, bit inv);
    int r;
    if (f == 1) r = v ^ 8192;
    else if (f == 2) r = v ^ (v / 2);
    else r = v;
    if (inv) r = 16383 - r;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m1v <= 0; m1d <= 0; m2v <= 0; m2d <= 0;
    end else begin
      m1v <= in_valid;
      if (in_valid) m1d <= clamp(int'(in_sample), int'($signed(cfg_offset)));
      m2v <= m1v && !cfg_disable;
      if (cfg_disable) m2d <= 0;
      else if (m1v) m2d <= code(m1d, int'(cfg_format), cfg_invert);
    end
  end

  task automatic compare();
    checks++;
    if (out_valid !== m2v || int'(out_data) != m2d) begin
      errors++;
      $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
               cur_req, out_valid, out_data, m2v, m2d[13:0]);
    end
  endtask

  task automatic step(input int s, input bit v);
    @(negedge clk);
    compare();
    in_sample = s[13:0];
    in_valid = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; compare();
    cur_req = "R2"; step(100, 1); step(0, 0); step(0, 0); step(0, 0);
    cur_req = "R3"; cfg_offset = 8'd20;
    for (int i = 0; i < 8; i++) step(1000 + i * 37, 1);
    cfg_offset = 8'hEC;
    for (int i = 0; i < 8; i++) step(5000 + i * 91, 1);
    cur_req = "R4"; cfg_offset = 8'd127;
    step(16383, 1); step(16300, 1); step(16256, 1); step(16257, 1);
    cur_req = "R5"; cfg_offset = 8'h80;
    step(0, 1); step(5, 1); step(128, 1); step(127, 1);
    cfg_offset = 8'd3;
    cur_req = "R6"; cfg_format = 2'b00;
    for (int i = 0; i < 6; i++) step(i * 2900, 1);
    cur_req = "R7"; cfg_format = 2'b01;
    for (int i = 0; i < 6; i++) step(i * 2900 + 11, 1);
    cur_req = "R8"; cfg_format = 2'b10;
    for (int i = 0; i < 6; i++) step(i * 2731 + 5, 1);
    cur_req = "R9"; cfg_format = 2'b11;
    for (int i = 0; i < 6; i++) step(i * 1777 + 9, 1);
    cur_req = "R10"; cfg_invert = 1;
    for (int f = 0; f < 3; f++) begin
      cfg_format = f[1:0];
      for (int i = 0; i < 3; i++) step(i * 4001 + 17, 1);
    end
    cfg_invert = 0; cfg_format = 2'b00;
    cur_req = "R11"; step(300, 1); cfg_disable = 1;
    step(400, 1); step(500, 1); step(600, 1);
    cfg_disable = 0; step(700, 1); step(800, 1); step(0, 0); step(0, 0);
    cur_req = "R12";
    step(1234, 1); step(0, 0); step(0, 0); step(4321, 1); step(0, 0); step(0, 0); step(0, 0);
    cfg_format = 2'b10; step(0, 0); step(0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule